// File: doc/BRIEF.md
# Fuzzy Inference Request Arbiter

This block settles contention for a single memory module among up to three processor requesters. Every requester presents a request bit and an unsigned fixed-point acceptance rate. The rate is the running fraction of its past requests that were served. Instead of a fixed or rotating order, the arbiter runs a small fuzzy inference engine each cycle. The engine classifies every active rate into soft low, medium and high sets. It evaluates a rule base that favours the requester with the poorest service so far. It then turns the fired rules into one crisp score per requester, and the highest score wins.

The grant is one-hot and registered, so it appears on the clock edge after the request and rate inputs are sampled. A requester that loses simply keeps its request raised and competes again in the following cycle. When only one request is present, the arbiter grants it without consulting the inference engine. The acceptance rates are computed elsewhere, and buses are allocated further downstream.

Top module: `fza_arbiter`

## Requirements
- R1: A rate r is unsigned Q0.8 (0..255, with 255 standing for one). For an active requester with r < 128, the degrees are low = 128 - r, medium = r and high = 0. For r >= 128 they are low = 0, medium = 255 - r and high = r - 127. The degree scale is 128 for full membership, and the three degrees always sum to 128.
- R2: The rule base holds one rule per combination of fuzzy classes over the active requesters. A rule's strength is the minimum of the degrees it names. The rule selects the active requester whose class is lowest, in the order low, medium, high. Equal classes go to the lower index. Example: requester 0 high at rate 255 against requester 1 low at rate 0 selects requester 1.
- R3: For each requester, the grant weight is the maximum strength over the rules that select it. The deny weight is the maximum strength over the rules that select any other requester.
- R4: Each requester's crisp score is the weighted average of a grant singleton at 255 and a deny singleton at 0: floor(255 * grant / (grant + deny)), or 0 when both weights are 0.
- R5: With two or three active requests, the active requester with the highest score is granted. Equal scores go to the lowest index.
- R6: The grant output has at most one bit set. It only names a requester that was requesting in the previous cycle, and it appears one clock after the inputs are sampled. Bit i of the request, grant and rate fields (rate bits 8i+7..8i) belong to requester i.
- R7: With exactly one request, that requester is granted on the next clock whatever its rate.
- R8: With no request, the next clock shows an all-zero grant and a low valid.
- R9: While reset is asserted, the grant is all zero and valid is low.
- R10: Valid is high exactly when some grant bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Request bit per requester |
| rate_i | input | 24 | Packed Q0.8 acceptance rates, requester i at bits 8i+7..8i |
| gnt_o | output | 3 | Registered one-hot grant |
| valid_o | output | 1 | Registered flag that a grant was issued |

## Verification
Fuzzy scoring and the index tie-break can decide the same cycle. Equal or mirrored rates give two requesters identical class patterns, and the floor in the weighted average can also make distinct weights produce equal scores. The bench provokes this with a sweep over every request pattern against a grid of rates. The grid includes the 127/128 class boundary and equal-rate triples. Each grant is judged against an arithmetic model of the membership, rule, aggregation, averaging and selection steps, which resolves ties toward the lower index.

// File: rtl/fza_pkg.sv
package fza_pkg;

  localparam int unsigned FZ_NREQ   = 3;
  localparam int unsigned FZ_RATE_W = 8;
  localparam int unsigned FZ_NCLS   = 4;
  localparam int unsigned FZ_CLS_W  = 2;

  // Fuzzy class index; CLS_NONE marks a requester that is not competing.
  typedef enum logic [FZ_CLS_W-1:0] {
    CLS_LOW  = 2'd0,
    CLS_MED  = 2'd1,
    CLS_HIGH = 2'd2,
    CLS_NONE = 2'd3
  } fz_cls_e;

  // Class that rule 'combo' assigns to requester 'idx'.
  function automatic int unsigned rule_class(input int unsigned combo,
                                             input int unsigned idx);
    return (combo >> (FZ_CLS_W * idx)) % FZ_NCLS;
  endfunction

  // Requester selected by a rule: lowest class, lower index on equal class.
  function automatic int unsigned rule_winner(input int unsigned combo,
                                              input int unsigned nreq);
    int unsigned best_cls;
    int unsigned best_idx;
    best_cls = FZ_NCLS;
    best_idx = 0;
    for (int unsigned i = 0; i < nreq; i++) begin
      if (rule_class(combo, i) < best_cls) begin
        best_cls = rule_class(combo, i);
        best_idx = i;
      end
    end
    return best_idx;
  endfunction

endpackage

// File: rtl/fza_fuzzifier.sv
module fza_fuzzifier
  import fza_pkg::*;
#(
  parameter int unsigned RATE_W = FZ_RATE_W
) (
  input  logic                              active_i,
  input  logic [RATE_W-1:0]                 rate_i,
  output logic [FZ_NCLS-1:0][RATE_W-1:0]    deg_o
);

  localparam logic [RATE_W-1:0] HALF     = RATE_W'(1) << (RATE_W - 1);
  localparam logic [RATE_W-1:0] FULL     = '1;
  localparam logic [RATE_W-1:0] HIGH_OFS = HALF - RATE_W'(1);

  // Triangular sets: low falls from the origin, medium peaks near one
  // half, high rises to full scale. Degrees form a partition of HALF.
  always_comb begin
    deg_o = '0;
    if (!active_i) begin
      deg_o[CLS_NONE] = HALF;
    end else if (rate_i < HALF) begin
      deg_o[CLS_LOW] = HALF - rate_i;
      deg_o[CLS_MED] = rate_i;
    end else begin
      deg_o[CLS_MED]  = FULL - rate_i;
      deg_o[CLS_HIGH] = rate_i - HIGH_OFS;
    end
  end

endmodule

// File: rtl/fza_rule_engine.sv
module fza_rule_engine
  import fza_pkg::*;
#(
  parameter int unsigned NREQ  = FZ_NREQ,
  parameter int unsigned DEG_W = FZ_RATE_W
) (
  input  logic [NREQ-1:0][FZ_NCLS-1:0][DEG_W-1:0] deg_i,
  output logic [NREQ-1:0][DEG_W-1:0]              wgrant_o,
  output logic [NREQ-1:0][DEG_W-1:0]              wdeny_o
);

  localparam int unsigned NCOMB = FZ_NCLS ** NREQ;

  // Every class combination is one rule. Combinations that place an active
  // requester in CLS_NONE, or an idle one elsewhere, have zero strength.
  always_comb begin
    logic [DEG_W-1:0] strength;
    int unsigned      win;
    wgrant_o = '0;
    wdeny_o  = '0;
    for (int unsigned k = 0; k < NCOMB; k++) begin
      strength = '1;
      for (int unsigned i = 0; i < NREQ; i++) begin
        if (deg_i[i][rule_class(k, i)] < strength) begin
          strength = deg_i[i][rule_class(k, i)];
        end
      end
      win = rule_winner(k, NREQ);
      for (int unsigned i = 0; i < NREQ; i++) begin
        if (i == win) begin
          if (strength > wgrant_o[i]) wgrant_o[i] = strength;
        end else begin
          if (strength > wdeny_o[i]) wdeny_o[i] = strength;
        end
      end
    end
  end

endmodule

// File: rtl/fza_defuzz.sv
module fza_defuzz
  import fza_pkg::*;
#(
  parameter int unsigned DEG_W   = FZ_RATE_W,
  parameter int unsigned SCORE_W = FZ_RATE_W
) (
  input  logic [DEG_W-1:0]   wgrant_i,
  input  logic [DEG_W-1:0]   wdeny_i,
  output logic [SCORE_W-1:0] score_o
);

  localparam int unsigned       NUM_W = DEG_W + SCORE_W;
  localparam logic [NUM_W-1:0]  PEAK  = NUM_W'((1 << SCORE_W) - 1);

  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] den;

  // Weighted average of the grant singleton (at PEAK) and deny singleton (at 0).
  always_comb begin
    num = NUM_W'(wgrant_i) * PEAK;
    den = NUM_W'(wgrant_i) + NUM_W'(wdeny_i);
    if (den == '0) begin
      score_o = '0;
    end else begin
      score_o = SCORE_W'(num / den);
    end
  end

endmodule

// File: rtl/fza_select.sv
module fza_select
  import fza_pkg::*;
#(
  parameter int unsigned NREQ    = FZ_NREQ,
  parameter int unsigned SCORE_W = FZ_RATE_W
) (
  input  logic [NREQ-1:0]               req_i,
  input  logic [NREQ-1:0][SCORE_W-1:0]  score_i,
  output logic [NREQ-1:0]               gnt_o
);

  always_comb begin
    logic               found;
    logic [SCORE_W-1:0] best;
    int unsigned        pick;
    found = 1'b0;
    best  = '0;
    pick  = 0;
    for (int unsigned i = 0; i < NREQ; i++) begin
      if (req_i[i] && (!found || (score_i[i] > best))) begin
        found = 1'b1;
        best  = score_i[i];
        pick  = i;
      end
    end
    gnt_o = '0;
    if ($countones(req_i) == 1) begin
      gnt_o = req_i;
    end else if (found) begin
      gnt_o[pick] = 1'b1;
    end
  end

endmodule

// File: rtl/fza_arbiter.sv
module fza_arbiter
  import fza_pkg::*;
#(
  parameter int unsigned NREQ   = FZ_NREQ,
  parameter int unsigned RATE_W = FZ_RATE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_i,
  input  logic [NREQ*RATE_W-1:0]   rate_i,
  output logic [NREQ-1:0]          gnt_o,
  output logic                     valid_o
);

  localparam int unsigned HALF_INT = 1 << (RATE_W - 1);

  logic [NREQ-1:0][FZ_NCLS-1:0][RATE_W-1:0] deg;
  logic [NREQ-1:0][RATE_W-1:0]              wgrant;
  logic [NREQ-1:0][RATE_W-1:0]              wdeny;
  logic [NREQ-1:0][RATE_W-1:0]              score;
  logic [NREQ-1:0]                          gnt_d;
  logic                                     valid_d;
  logic                                     load_en;
  logic [NREQ-1:0]                          gnt_q;
  logic                                     valid_q;

  generate
    for (genvar gi = 0; gi < NREQ; gi++) begin : g_req
      fza_fuzzifier #(.RATE_W(RATE_W)) u_fuzz (
        .active_i (req_i[gi]),
        .rate_i   (rate_i[gi*RATE_W +: RATE_W]),
        .deg_o    (deg[gi])
      );

      fza_defuzz #(.DEG_W(RATE_W), .SCORE_W(RATE_W)) u_defuzz (
        .wgrant_i (wgrant[gi]),
        .wdeny_i  (wdeny[gi]),
        .score_o  (score[gi])
      );

      // R1: membership degrees of every requester form a partition of one
      a_r1_partition: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(deg[gi][0]) + 32'(deg[gi][1]) + 32'(deg[gi][2]) + 32'(deg[gi][3]))
          == HALF_INT);
    end
  endgenerate

  fza_rule_engine #(.NREQ(NREQ), .DEG_W(RATE_W)) u_rules (
    .deg_i    (deg),
    .wgrant_o (wgrant),
    .wdeny_o  (wdeny)
  );

  fza_select #(.NREQ(NREQ), .SCORE_W(RATE_W)) u_select (
    .req_i   (req_i),
    .score_i (score),
    .gnt_o   (gnt_d)
  );

  // Next state
  always_comb begin
    valid_d = |gnt_d;
    load_en = (|req_i) | valid_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_en) begin
      gnt_q   <= gnt_d;
      valid_q <= valid_d;
    end
  end

  assign gnt_o   = gnt_q;
  assign valid_o = valid_q;

  // R6: never more than one grant
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R6: grant names only a requester of the previous cycle
  a_r6_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> ((gnt_q & ~$past(req_i)) == '0));

  // R7: a lone request is granted directly
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(req_i) |=> (gnt_q == $past(req_i)));

  // R8: no request leaves nothing granted
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> !valid_q);

  // R5: contention always produces a grant
  a_r5_contend: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_i) > 1) |=> valid_q);

  // R10: valid flags a set grant bit
  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == (gnt_q != '0));

endmodule

// File: tb/fza_arbiter_bench.sv
`timescale 1ns/1ps
module fza_arbiter_bench;

  logic        clk;
  logic        rst_n;
  logic [2:0]  req;
  logic [23:0] rate;
  logic [2:0]  gnt;
  logic        valid;

  int checks;
  int errors;

  fza_arbiter u_fza_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .rate_i  (rate),
    .gnt_o   (gnt),
    .valid_o (valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Membership degree of class c (0 low, 1 medium, 2 high, 3 idle), per R1.
  function automatic int degree(input int r, input int c, input bit act);
    if (!act) return (c == 3) ? 128 : 0;
    case (c)
      0: return (r < 128) ? 128 - r : 0;
      1: return (r < 128) ? r : 255 - r;
      2: return (r >= 128) ? r - 127 : 0;
      default: return 0;
    endcase
  endfunction

  // Arithmetic model of R1 to R5 and R7/R8.
  function automatic logic [2:0] model(input logic [2:0] rq, input logic [23:0] rt);
    int wg[3];
    int wd[3];
    int sc[3];
    int n;
    int best;
    int pick;
    bit found;
    logic [2:0] g;
    for (int i = 0; i < 3; i++) begin wg[i] = 0; wd[i] = 0; end
    for (int k = 0; k < 64; k++) begin
      int s;
      int wcls;
      int win;
      s = 1000; wcls = 4; win = 0;
      for (int i = 0; i < 3; i++) begin
        int c;
        int d;
        c = (k >> (2 * i)) & 3;
        d = degree(int'(rt[8*i +: 8]), c, rq[i]);
        if (d < s) s = d;
        if (c < wcls) begin wcls = c; win = i; end
      end
      for (int i = 0; i < 3; i++) begin
        if (i == win) begin if (s > wg[i]) wg[i] = s; end
        else          begin if (s > wd[i]) wd[i] = s; end
      end
    end
    for (int i = 0; i < 3; i++)
      sc[i] = (wg[i] + wd[i] == 0) ? 0 : (255 * wg[i]) / (wg[i] + wd[i]);
    n = 0;
    for (int i = 0; i < 3; i++) if (rq[i]) n++;
    g = 3'b000;
    if (n == 1) begin
      g = rq;
    end else if (n > 1) begin
      found = 1'b0; best = 0; pick = 0;
      for (int i = 0; i < 3; i++)
        if (rq[i] && (!found || sc[i] > best)) begin found = 1'b1; best = sc[i]; pick = i; end
      g[pick] = 1'b1;
    end
    return g;
  endfunction

  task automatic check_out(input logic [2:0] exp_g, input string tag);
    checks++;
    if (gnt !== exp_g) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b (req=%b rate=%h)", tag, gnt, exp_g, req, rate);
    end
    checks++;
    if (valid !== (exp_g != 3'b000)) begin
      errors++;
      $display("FAIL R10 valid actual=%b expected=%b", valid, (exp_g != 3'b000));
    end
  endtask

  // Drive on a falling edge, let one rising edge register, check on the next falling edge.
  task automatic apply(input logic [2:0] rq, input logic [23:0] rt, input string tag,
                       input logic [2:0] exp_g);
    @(negedge clk);
    req  = rq;
    rate = rt;
    @(negedge clk);
    check_out(exp_g, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] grid [8];
    grid = '{8'd0, 8'd40, 8'd90, 8'd127, 8'd128, 8'd170, 8'd220, 8'd255};
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    req    = 3'b111;
    rate   = 24'h00_80_FF;
    repeat (3) @(negedge clk);
    check_out(3'b000, "R9");
    rst_n = 1'b1;

    // R2: high-rate requester 0 loses to low-rate requester 1
    apply(3'b011, {8'd0, 8'd0, 8'd255}, "R2", 3'b010);
    // R1: class boundary, rate 127 is medium/low, 128 is medium/high
    apply(3'b011, {8'd0, 8'd128, 8'd127}, "R1", 3'b001);
    // R3: equal low classes fold into requester 0's grant weight
    apply(3'b111, {8'd0, 8'd0, 8'd0}, "R3", 3'b001);
    // R4: weighted-average scores with mixed memberships
    apply(3'b110, {8'd200, 8'd60, 8'd0}, "R4", model(3'b110, {8'd200, 8'd60, 8'd0}));
    // R5: full-rate tie among all three goes to index 0
    apply(3'b111, {8'd255, 8'd255, 8'd255}, "R5", 3'b001);
    // R7: lone request at full rate
    apply(3'b100, {8'd255, 8'd0, 8'd0}, "R7", 3'b100);
    // R8: no request
    apply(3'b000, {8'd0, 8'd0, 8'd0}, "R8", 3'b000);

    // R6: output holds until the next rising edge
    @(negedge clk);
    req  = 3'b010;
    rate = 24'h10_20_30;
    #2;
    check_out(3'b000, "R6");
    @(negedge clk);
    check_out(3'b010, "R6");

    // Sweep: every request pattern against a grid of rates
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          for (int c = 0; c < 8; c++) begin
            logic [23:0] rt;
            logic [2:0]  rq;
            string       tag;
            rq = 3'(p);
            rt = {grid[c], grid[b], grid[a]};
            if (rq == 3'b000)                 tag = "R8";
            else if ($countones(rq) == 1)     tag = "R7";
            else                              tag = "R5";
            apply(rq, rt, tag, model(rq, rt));
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule